// File: doc/BRIEF.md
# Paired-Write Register File

This block is the integer register file of an in-order core: 32 registers of 32 bits, with three combinational read ports and two clocked write ports. Two of the read ports take their own addresses. The third read port has no address input and always returns the register named by the destination address, which is how accumulate-style dot-product instructions fetch their accumulator. The first write port targets the destination register. The second write port always targets the register one above it, so widening instructions can write a result pair in a single cycle.

With the `BANKED` parameter set, the default, storage is split into an even-register bank and an odd-register bank of half the depth each. A paired write then always puts one write in each bank, and each bank needs only one write port. With `BANKED` cleared, a single array with two write ports is built instead. Both variants behave the same at the ports.

Reads and writes are plain control and data pins with no handshake. A read needs no request and a write always completes in its cycle, so there is no back-pressure to express. Forwarding and hazard detection belong to the surrounding pipeline.

Top module: `pairwr_regfile`

## Requirements
- R1: Register 0 reads as zero on all three read ports, whatever is written to it; a write from the first port with a destination address of 0 is discarded.
- R2: When `wr_main_en` is 1 at a rising clock edge and `dst_addr` is not 0, register `dst_addr` takes `wr_main_data`, and it is visible on the read ports from that edge onward.
- R3: When `wr_pair_en` is 1 at a rising clock edge and `dst_addr` is below 31, register `dst_addr + 1` takes `wr_pair_data`. With `dst_addr` equal to 0 this writes register 1.
- R4: When `wr_pair_en` is 1 with `dst_addr` equal to 31, the second write is dropped: it does not wrap to register 0 and it changes no register.
- R5: `acc_data` always equals the current contents of register `dst_addr` (zero when `dst_addr` is 0).
- R6: Reads are combinational. A read of a register that is being written in the same cycle returns the value held before the clock edge.
- R7: The two write enables act independently. A write on one port alone leaves the other port's target register unchanged, and in a cycle with both enables low no register changes.
- R8: An asynchronous active-low reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| src_a_addr | input | 5 | Address of read port A |
| src_b_addr | input | 5 | Address of read port B |
| dst_addr | input | 5 | Destination register: target of the main write, base of the paired write, address of the accumulator read |
| wr_main_en | input | 1 | Write enable for register `dst_addr` |
| wr_main_data | input | 32 | Data for the main write |
| wr_pair_en | input | 1 | Write enable for register `dst_addr + 1` |
| wr_pair_data | input | 32 | Data for the paired write |
| src_a_data | output | 32 | Contents of register `src_a_addr` |
| src_b_data | output | 32 | Contents of register `src_b_addr` |
| acc_data | output | 32 | Contents of register `dst_addr` |

## Verification
The assertions check on every cycle that register 0 reads as zero, that the accumulator port agrees with port A whenever both name the same register, and that a main or paired write shows up on the following cycle. They also check that with no write enabled a held read address returns a held value, and that a paired write at destination 31 leaves register 31 alone. The bench scenarios show the things a one-cycle property cannot: the cleared state after reset across all 32 registers, that a dropped wrap leaves register 1 unchanged, that the untouched partner of a single write keeps an older value, and that a read during a write returns the old contents. A long mixed random run is then compared every cycle against a behavioural model, which covers both bank orderings (even destination and odd destination).

// File: rtl/pairwr_pkg.sv
package pairwr_pkg;
  localparam int unsigned DEF_XLEN  = 32;
  localparam int unsigned DEF_NREGS = 32;
  // read port slots used inside the block
  localparam int unsigned RD_PORTS  = 3;
  localparam int unsigned SLOT_A    = 0;
  localparam int unsigned SLOT_B    = 1;
  localparam int unsigned SLOT_ACC  = 2;
endpackage

// File: rtl/pairwr_wr_decode.sv
module pairwr_wr_decode #(
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input  logic [AW-1:0] dst_addr,
  input  logic          main_en,
  input  logic          pair_en,
  output logic          main_go,
  output logic          pair_go,
  output logic [AW-1:0] pair_addr
);
  localparam logic [AW-1:0] TOP_REG = AW'(NREGS - 1);

  always_comb begin
    pair_addr = dst_addr + AW'(1);
    // register 0 is never written
    main_go   = main_en && (dst_addr != '0);
    // no wrap from the last register back to register 0
    pair_go   = pair_en && (dst_addr != TOP_REG);
  end
endmodule

// File: rtl/pairwr_bank.sv
module pairwr_bank #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned XLEN = 32,
  parameter int unsigned NWR  = 1,
  parameter int unsigned NRD  = 3,
  localparam int unsigned RAW = $clog2(ROWS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NWR-1:0]            we,
  input  logic [NWR-1:0][RAW-1:0]   waddr,
  input  logic [NWR-1:0][XLEN-1:0]  wdata,
  input  logic [NRD-1:0][RAW-1:0]   raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      for (int w = 0; w < NWR; w++) begin
        if (we[w]) mem[waddr[w]] <= wdata[w];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end
endmodule

// File: rtl/pairwr_rd_mux.sv
module pairwr_rd_mux #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned AW     = 5,
  parameter bit          BANKED = 1'b1
) (
  input  logic [AW-1:0]   addr,
  input  logic [XLEN-1:0] even_data,
  input  logic [XLEN-1:0] odd_data,
  output logic [XLEN-1:0] data
);
  logic [XLEN-1:0] picked;

  if (BANKED) begin : g_two
    assign picked = addr[0] ? odd_data : even_data;
  end else begin : g_one
    logic unused_odd;
    assign unused_odd = ^odd_data;
    assign picked = even_data;
  end

  assign data = (addr == '0) ? '0 : picked;
endmodule

// File: rtl/pairwr_regfile.sv
module pairwr_regfile
  import pairwr_pkg::*;
#(
  parameter int unsigned XLEN   = DEF_XLEN,
  parameter int unsigned NREGS  = DEF_NREGS,
  parameter bit          BANKED = 1'b1,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   src_a_addr,
  input  logic [AW-1:0]   src_b_addr,
  input  logic [AW-1:0]   dst_addr,
  input  logic            wr_main_en,
  input  logic [XLEN-1:0] wr_main_data,
  input  logic            wr_pair_en,
  input  logic [XLEN-1:0] wr_pair_data,
  output logic [XLEN-1:0] src_a_data,
  output logic [XLEN-1:0] src_b_data,
  output logic [XLEN-1:0] acc_data
);
  localparam int unsigned NBANK = BANKED ? 2 : 1;
  localparam int unsigned ROWS  = NREGS / NBANK;
  localparam int unsigned RAW   = $clog2(ROWS);

  logic          main_go, pair_go;
  logic [AW-1:0] pair_addr;

  pairwr_wr_decode #(.NREGS(NREGS)) dec_i (
    .dst_addr (dst_addr),
    .main_en  (wr_main_en),
    .pair_en  (wr_pair_en),
    .main_go  (main_go),
    .pair_go  (pair_go),
    .pair_addr(pair_addr)
  );

  logic [RD_PORTS-1:0][AW-1:0]   rd_addr_all;
  logic [RD_PORTS-1:0][XLEN-1:0] even_q, odd_q, rd_out;

  assign rd_addr_all[SLOT_A]   = src_a_addr;
  assign rd_addr_all[SLOT_B]   = src_b_addr;
  assign rd_addr_all[SLOT_ACC] = dst_addr;

  if (BANKED) begin : g_banked
    logic [RD_PORTS-1:0][RAW-1:0] row_addr;
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_row
      assign row_addr[p] = rd_addr_all[p][AW-1:1];
    end

    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic                       b_we;
      logic [0:0][RAW-1:0]        b_waddr;
      logic [0:0][XLEN-1:0]       b_wdata;
      logic [RD_PORTS-1:0][XLEN-1:0] b_q;

      // the main and the paired write always land in opposite banks
      always_comb begin
        b_we       = 1'b0;
        b_waddr[0] = dst_addr[AW-1:1];
        b_wdata[0] = wr_main_data;
        if (main_go && (dst_addr[0] == 1'(b))) begin
          b_we       = 1'b1;
        end else if (pair_go && (pair_addr[0] == 1'(b))) begin
          b_we       = 1'b1;
          b_waddr[0] = pair_addr[AW-1:1];
          b_wdata[0] = wr_pair_data;
        end
      end

      pairwr_bank #(.ROWS(ROWS), .XLEN(XLEN), .NWR(1), .NRD(RD_PORTS)) bank_i (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (b_we),
        .waddr(b_waddr),
        .wdata(b_wdata),
        .raddr(row_addr),
        .rdata(b_q)
      );

      if (b == 0) begin : g_even
        assign even_q = b_q;
      end else begin : g_odd
        assign odd_q = b_q;
      end
    end
  end else begin : g_flat
    logic [1:0]           f_we;
    logic [1:0][AW-1:0]   f_waddr;
    logic [1:0][XLEN-1:0] f_wdata;

    assign f_we    = {pair_go, main_go};
    assign f_waddr = {pair_addr, dst_addr};
    assign f_wdata = {wr_pair_data, wr_main_data};

    pairwr_bank #(.ROWS(NREGS), .XLEN(XLEN), .NWR(2), .NRD(RD_PORTS)) bank_i (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (f_we),
      .waddr(f_waddr),
      .wdata(f_wdata),
      .raddr(rd_addr_all),
      .rdata(even_q)
    );
    assign odd_q = even_q;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_mux
    pairwr_rd_mux #(.XLEN(XLEN), .AW(AW), .BANKED(BANKED)) mux_i (
      .addr     (rd_addr_all[p]),
      .even_data(even_q[p]),
      .odd_data (odd_q[p]),
      .data     (rd_out[p])
    );
  end

  assign src_a_data = rd_out[SLOT_A];
  assign src_b_data = rd_out[SLOT_B];
  assign acc_data   = rd_out[SLOT_ACC];
endmodule

// File: rtl/pairwr_regfile_chk.sv
module pairwr_regfile_chk #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW   = $clog2(NREGS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   src_a_addr,
  input logic [AW-1:0]   src_b_addr,
  input logic [AW-1:0]   dst_addr,
  input logic            wr_main_en,
  input logic [XLEN-1:0] wr_main_data,
  input logic            wr_pair_en,
  input logic [XLEN-1:0] wr_pair_data,
  input logic [XLEN-1:0] src_a_data,
  input logic [XLEN-1:0] src_b_data,
  input logic [XLEN-1:0] acc_data
);
  localparam logic [AW-1:0] TOP_REG = AW'(NREGS - 1);

  p_zero_a_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_addr == '0) |-> (src_a_data == '0));
  p_zero_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (src_b_addr == '0) |-> (src_b_data == '0));
  p_zero_acc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_addr == '0) |-> (acc_data == '0));

  p_main_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_main_en && dst_addr != '0) |=>
      ((src_a_addr == $past(dst_addr)) -> (src_a_data == $past(wr_main_data))));

  p_pair_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pair_en && dst_addr != TOP_REG) |=>
      ((src_b_addr == AW'($past(dst_addr) + AW'(1))) -> (src_b_data == $past(wr_pair_data))));

  p_no_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pair_en && !wr_main_en && dst_addr == TOP_REG) |=>
      ((dst_addr == TOP_REG) -> (acc_data == $past(acc_data))));

  p_acc_matches_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_addr == dst_addr) |-> (acc_data == src_a_data));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_main_en && !wr_pair_en) |=>
      ($stable(src_a_addr) -> $stable(src_a_data)));
endmodule

bind pairwr_regfile pairwr_regfile_chk #(.XLEN(XLEN), .NREGS(NREGS)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .src_a_addr  (src_a_addr),
  .src_b_addr  (src_b_addr),
  .dst_addr    (dst_addr),
  .wr_main_en  (wr_main_en),
  .wr_main_data(wr_main_data),
  .wr_pair_en  (wr_pair_en),
  .wr_pair_data(wr_pair_data),
  .src_a_data  (src_a_data),
  .src_b_data  (src_b_data),
  .acc_data    (acc_data)
);

// File: tb/pairwr_regfile_tb.sv
module pairwr_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  src_a_addr = '0, src_b_addr = '0, dst_addr = '0;
  logic        wr_main_en = 1'b0, wr_pair_en = 1'b0;
  logic [31:0] wr_main_data = '0, wr_pair_data = '0;
  logic [31:0] src_a_data, src_b_data, acc_data;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  pairwr_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .src_a_addr(src_a_addr), .src_b_addr(src_b_addr), .dst_addr(dst_addr),
    .wr_main_en(wr_main_en), .wr_main_data(wr_main_data),
    .wr_pair_en(wr_pair_en), .wr_pair_data(wr_pair_data),
    .src_a_data(src_a_data), .src_b_data(src_b_data), .acc_data(acc_data)
  );

  task automatic check1(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive at negedge, compare against pre-edge model, then apply edge to model
  task automatic step(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                      input logic e0, input logic [31:0] d0,
                      input logic e1, input logic [31:0] d1, input string tag);
    @(negedge clk);
    src_a_addr = a; src_b_addr = b; dst_addr = d;
    wr_main_en = e0; wr_main_data = d0; wr_pair_en = e1; wr_pair_data = d1;
    #1;
    check1(tag, "port A", src_a_data, model[a]);
    check1(tag, "port B", src_b_data, model[b]);
    check1(tag, "acc",    acc_data,   model[d]);
    @(posedge clk);
    if (e0 && d != 5'd0)  model[d] = d0;
    if (e1 && d != 5'd31) model[d + 5'd1] = d1;
  endtask

  task automatic rd3(input logic [4:0] a, input logic [4:0] b, input logic [4:0] d,
                     input string tag);
    step(a, b, d, 1'b0, '0, 1'b0, '0, tag);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: every register cleared after reset
    for (int i = 0; i < 32; i += 3)
      rd3(5'(i), 5'(i + 1), 5'(i + 2), "R8");

    // R2: main write, visible next cycle
    step(5'd5, 5'd6, 5'd5, 1'b1, 32'hA5A5_0005, 1'b0, '0, "R2");
    rd3(5'd5, 5'd4, 5'd5, "R2");

    // R3: paired write, even base then odd base
    step(5'd6, 5'd7, 5'd6, 1'b1, 32'h1111_0006, 1'b1, 32'h2222_0007, "R3");
    rd3(5'd6, 5'd7, 5'd6, "R3");
    step(5'd9, 5'd10, 5'd9, 1'b1, 32'h3333_0009, 1'b1, 32'h4444_000A, "R3");
    rd3(5'd9, 5'd10, 5'd10, "R3");

    // R7: single write on either port leaves the other target alone
    step(5'd20, 5'd21, 5'd20, 1'b1, 32'hCAFE_0014, 1'b1, 32'hCAFE_0015, "R7");
    step(5'd20, 5'd21, 5'd20, 1'b0, 32'hDEAD_0000, 1'b1, 32'hBEEF_0015, "R7");
    rd3(5'd20, 5'd21, 5'd20, "R7");
    step(5'd20, 5'd21, 5'd20, 1'b1, 32'h0BAD_0014, 1'b0, 32'hDEAD_0001, "R7");
    rd3(5'd20, 5'd21, 5'd21, "R7");
    step(5'd20, 5'd21, 5'd20, 1'b0, 32'hFFFF_FFFF, 1'b0, 32'hFFFF_FFFF, "R7");
    rd3(5'd20, 5'd21, 5'd20, "R7");

    // R1: writes aimed at register 0 ignored; pair from 0 writes register 1
    step(5'd0, 5'd1, 5'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 32'h0000_0101, "R1");
    rd3(5'd0, 5'd1, 5'd0, "R1");

    // R4: pair at 31 drops second write, register 0 and 1 unchanged
    step(5'd31, 5'd1, 5'd31, 1'b1, 32'h7777_001F, 1'b1, 32'h9999_9999, "R4");
    rd3(5'd0, 5'd1, 5'd31, "R4");
    step(5'd31, 5'd0, 5'd31, 1'b0, '0, 1'b1, 32'h5555_5555, "R4");
    rd3(5'd0, 5'd1, 5'd31, "R4");

    // R6: read of register under write returns old contents
    step(5'd12, 5'd13, 5'd12, 1'b1, 32'h6666_000C, 1'b1, 32'h6666_000D, "R6");
    step(5'd12, 5'd13, 5'd12, 1'b1, 32'h7777_000C, 1'b1, 32'h7777_000D, "R6");
    rd3(5'd12, 5'd13, 5'd12, "R6");

    // R5: accumulator port follows destination address
    for (int i = 0; i < 32; i += 5)
      rd3(5'd0, 5'd0, 5'(i), "R5");

    // mixed random traffic compared every cycle
    for (int n = 0; n < 400; n++)
      step(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom), $urandom,
           1'($urandom), $urandom, "R2");
    for (int i = 0; i < 32; i += 3)
      rd3(5'(i), 5'(i + 1), 5'(i + 2), "R3");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule